// File: doc/BRIEF.md
# Chip Reset Sequencer with Source Classification

This block is the chip-level reset generator. It collects six reset requests and starts a reset sequence as soon as any of them is raised, with no clock edge needed. The requests are power-on, low supply voltage, an illegal-address access, a watchdog timeout, a clock-monitor failure (honoured only while self-clock mode is off), and an external low level on the reset pad. The block then drives the open-drain reset pad low for a fixed number of system clocks and lets it go. It waits a further fixed interval and reads the pad back through a synchronizer.

The pad level it reads decides which vector class the rest of the chip should fetch. A pad still low means something outside is holding reset, so the external/power-on class is chosen. A pad that has risen lets the latched clock-monitor and watchdog flags decide, with clock-monitor first. The internal reset stays asserted for the whole sequence and releases one clock after the vector selection is published.

Top module: `rst_sequencer`

## Requirements
- R1: Raising por_req, lvd_req, bad_addr_req, wdog_req or clkmon_fail (with selfclk_en=0), or pulling rst_pad_in low while the block is idle, sets rst_pad_drv_low=1 and sys_rst_n=0 at once, without a clock edge.
- R2: clkmon_fail raised while selfclk_en=1 has no effect. No pad drive, sys_rst_n stays 1, and no clock-monitor flag is kept, so a later sequence started by another source reports vec_sel=2'b00.
- R3: rst_pad_drv_low falls on the 132nd rising clock edge after the last request is withdrawn. That is 128 drive clocks, plus 2 synchronizer clocks, plus 2 fixed extra clocks.
- R4: With the pad high, vec_valid rises on the 64th rising edge after the edge that released the pad. The pad level used is the one seen through a 2-flop synchronizer at that edge.
- R5: If the sampled pad is low, vec_sel=2'b00 whatever flags are pending. sys_rst_n and vec_valid stay 0 until the synchronized pad reads high.
- R6: If the sampled pad is high and a clock-monitor reset is pending, vec_sel=2'b01 whatever the watchdog flag is.
- R7: If the sampled pad is high with only a watchdog reset pending, vec_sel=2'b10. With no flag pending, vec_sel=2'b00.
- R8: sys_rst_n rises exactly one clock after vec_valid rises. vec_valid and vec_sel then hold until the next reset entry, and entry clears vec_valid at once.
- R9: Pending watchdog and clock-monitor flags are cleared when sys_rst_n rises. A following sequence without those events reports 2'b00.
- R10: A new request during a sequence restarts the drive count, so the pad is released 132 edges after that request is withdrawn. Flags latched earlier are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high; also clears the pending flags |
| lvd_req | input | 1 | Low-voltage request, active high |
| bad_addr_req | input | 1 | Illegal-address request, active high |
| wdog_req | input | 1 | Watchdog timeout request, active high |
| clkmon_fail | input | 1 | Clock-monitor failure, active high |
| selfclk_en | input | 1 | Self-clock mode on; masks clkmon_fail |
| rst_pad_in | input | 1 | Level read from the reset pad |
| rst_pad_drv_low | output | 1 | Enable of the open-drain pull-down on the pad |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| vec_sel | output | 2 | Vector class: 00 external/power-on, 01 clock monitor, 10 watchdog |
| vec_valid | output | 1 | vec_sel holds the class of the last sequence |

## Verification
A drive or wait counter that is off by even one shows as a shifted falling edge on rst_pad_drv_low, or a shifted rising edge on vec_valid. Both are measured to the exact clock, so the error is visible within about 200 clocks of the request. A wrong pending flag or a wrong priority decision shows as a wrong vec_sel code in that same sequence. A flag that is not cleared shows up one sequence later, as a watchdog or clock-monitor code where 00 was due. A broken restart or a wrong pad-hold decision shows either as a pad released too soon, or as sys_rst_n rising while the pad is still held low.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_DRIVE   = 3'd0,
    ST_WAIT    = 3'd1,
    ST_EXTHOLD = 3'd2,
    ST_DONE    = 3'd3,
    ST_IDLE    = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    VEC_EXT    = 2'b00,
    VEC_CLKMON = 2'b01,
    VEC_WDOG   = 2'b10
  } vec_e;

  // Priority: pad still low wins, then clock monitor, then watchdog.
  function automatic vec_e pick_vec(input logic pad_hi, input logic cm_pend,
                                    input logic wd_pend);
    vec_e v;
    if (!pad_hi)      v = VEC_EXT;
    else if (cm_pend) v = VEC_CLKMON;
    else if (wd_pend) v = VEC_WDOG;
    else              v = VEC_EXT;
    return v;
  endfunction

endpackage

// File: rtl/rstseq_req_sync.sv
// Reset-style synchronizer: asserts the sequence reset asynchronously on any
// trigger, releases it after STAGES clock edges.
module rstseq_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic trig_i,
  output logic seq_rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or posedge trig_i) begin
    if (trig_i) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign seq_rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_pin_sync.sv
// Data synchronizer for the pad level; forced high while the sequence is reset.
module rstseq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '1;
    else          sync_q <= sync_d;
  end

  assign pin_o = sync_q[STAGES-1];

endmodule

// File: rtl/rstseq_pend.sv
// Pending-source flag: cleared by power-on, set asynchronously by its event,
// cleared synchronously when the sequence completes.
module rstseq_pend (
  input  logic clk_i,
  input  logic por_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or posedge por_i or posedge set_i) begin
    if (por_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else            flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int DRIVE_LEN = 130,
  parameter int WAIT_LEN  = 64
) (
  input  logic       clk_i,
  input  logic       seq_rst_n_i,
  input  logic       pad_hi_i,
  input  logic       cm_pend_i,
  input  logic       wd_pend_i,
  output logic       drv_low_o,
  output logic       sys_rst_n_o,
  output logic       clr_pend_o,
  output logic [1:0] vec_sel_o,
  output logic       vec_valid_o
);

  localparam int MAX_LEN = (DRIVE_LEN > WAIT_LEN) ? DRIVE_LEN : WAIT_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_LEN - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  vec_e             vec_q, vec_d;
  logic             vec_ld;
  logic             valid_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    vec_d   = vec_q;
    vec_ld  = 1'b0;
    case (state_q)
      ST_DRIVE: begin
        cnt_en = 1'b1;
        if (cnt_q == DRIVE_LAST) begin
          cnt_d   = '0;
          state_d = ST_WAIT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == WAIT_LAST) begin
          cnt_d = '0;
          if (pad_hi_i) begin
            vec_d   = pick_vec(pad_hi_i, cm_pend_i, wd_pend_i);
            vec_ld  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_EXTHOLD;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_EXTHOLD: begin
        if (pad_hi_i) begin
          vec_d   = VEC_EXT;
          vec_ld  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_IDLE: state_d = ST_IDLE;
      default: state_d = ST_DRIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge seq_rst_n_i) begin
    if (!seq_rst_n_i) begin
      state_q <= ST_DRIVE;
      cnt_q   <= '0;
      vec_q   <= VEC_EXT;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (vec_ld) begin
        vec_q   <= vec_d;
        valid_q <= 1'b1;
      end
    end
  end

  assign drv_low_o   = (state_q == ST_DRIVE);
  assign sys_rst_n_o = (state_q == ST_IDLE);
  assign clr_pend_o  = (state_q == ST_DONE);
  assign vec_sel_o   = vec_q;
  assign vec_valid_o = valid_q;

  // R3
  drive_len_chk: assert property (@(posedge clk_i) disable iff (!seq_rst_n_i)
    $fell(drv_low_o) |-> ($past(cnt_q) == DRIVE_LAST));

  // R8
  rst_after_vec_chk: assert property (@(posedge clk_i) disable iff (!seq_rst_n_i)
    $rose(sys_rst_n_o) |-> $past(vec_valid_o));

  // R5
  pad_hold_chk: assert property (@(posedge clk_i) disable iff (!seq_rst_n_i)
    (state_q == ST_EXTHOLD && !pad_hi_i) |=> (!sys_rst_n_o && !vec_valid_o));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYC   = 128,
  parameter int EXTRA_CYC   = 2,
  parameter int WAIT_CYC    = 64,
  parameter int REQ_STAGES  = 2,
  parameter int PAD_STAGES  = 2
) (
  input  logic       clk_sys,
  input  logic       por_req,
  input  logic       lvd_req,
  input  logic       bad_addr_req,
  input  logic       wdog_req,
  input  logic       clkmon_fail,
  input  logic       selfclk_en,
  input  logic       rst_pad_in,
  output logic       rst_pad_drv_low,
  output logic       sys_rst_n,
  output logic [1:0] vec_sel,
  output logic       vec_valid
);

  localparam int DRIVE_LEN = DRIVE_CYC + EXTRA_CYC;

  logic cm_evt;
  logic ext_evt;
  logic trig;
  logic seq_rst_n;
  logic pad_hi;
  logic cm_pend;
  logic wd_pend;
  logic clr_pend;

  assign cm_evt  = clkmon_fail & ~selfclk_en;
  // The pad counts as a request only while idle; afterwards it is only read back.
  assign ext_evt = sys_rst_n & ~rst_pad_in;
  assign trig    = por_req | lvd_req | bad_addr_req | wdog_req | cm_evt | ext_evt;

  rstseq_req_sync #(.STAGES(REQ_STAGES)) u_req_sync (
    .clk_i       (clk_sys),
    .trig_i      (trig),
    .seq_rst_n_o (seq_rst_n)
  );

  rstseq_pin_sync #(.STAGES(PAD_STAGES)) u_pad_sync (
    .clk_i   (clk_sys),
    .rst_n_i (seq_rst_n),
    .pin_i   (rst_pad_in),
    .pin_o   (pad_hi)
  );

  rstseq_pend u_cm_pend (
    .clk_i  (clk_sys),
    .por_i  (por_req),
    .set_i  (cm_evt),
    .clr_i  (clr_pend),
    .flag_o (cm_pend)
  );

  rstseq_pend u_wd_pend (
    .clk_i  (clk_sys),
    .por_i  (por_req),
    .set_i  (wdog_req),
    .clr_i  (clr_pend),
    .flag_o (wd_pend)
  );

  rstseq_fsm #(.DRIVE_LEN(DRIVE_LEN), .WAIT_LEN(WAIT_CYC)) u_fsm (
    .clk_i       (clk_sys),
    .seq_rst_n_i (seq_rst_n),
    .pad_hi_i    (pad_hi),
    .cm_pend_i   (cm_pend),
    .wd_pend_i   (wd_pend),
    .drv_low_o   (rst_pad_drv_low),
    .sys_rst_n_o (sys_rst_n),
    .clr_pend_o  (clr_pend),
    .vec_sel_o   (vec_sel),
    .vec_valid_o (vec_valid)
  );

  // R7
  wdog_prio_chk: assert property (@(posedge clk_sys) disable iff (!seq_rst_n)
    ($rose(vec_valid) && vec_sel == VEC_WDOG) |-> ($past(wd_pend) && !$past(cm_pend)));

  // R6
  clkmon_prio_chk: assert property (@(posedge clk_sys) disable iff (!seq_rst_n)
    ($rose(vec_valid) && vec_sel == VEC_CLKMON) |-> $past(cm_pend));

  // R9
  pend_clr_chk: assert property (@(posedge clk_sys) disable iff (!seq_rst_n)
    $rose(sys_rst_n) |-> (!wd_pend && !cm_pend));

endmodule

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REL_EDGES  = 128 + 2 + 2;
  localparam int WAIT_EDGES = 64;

  logic clk = 1'b0;
  logic por_req, lvd_req, bad_addr_req, wdog_req, clkmon_fail, selfclk_en;
  logic ext_low;
  logic rst_pad_in, rst_pad_drv_low, sys_rst_n, vec_valid;
  logic [1:0] vec_sel;

  int tests = 0;
  int fails = 0;
  bit exp_wd = 0;
  bit exp_cm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rst_pad_in = !(rst_pad_drv_low | ext_low);

  rst_sequencer u_rst_sequencer (
    .clk_sys         (clk),
    .por_req         (por_req),
    .lvd_req         (lvd_req),
    .bad_addr_req    (bad_addr_req),
    .wdog_req        (wdog_req),
    .clkmon_fail     (clkmon_fail),
    .selfclk_en      (selfclk_en),
    .rst_pad_in      (rst_pad_in),
    .rst_pad_drv_low (rst_pad_drv_low),
    .sys_rst_n       (sys_rst_n),
    .vec_sel         (vec_sel),
    .vec_valid       (vec_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_vec(input bit pad_low, input bit cm, input bit wd);
    if (pad_low) return 0;
    if (cm)      return 1;
    if (wd)      return 2;
    return 0;
  endfunction

  task automatic apply(input int kind, input logic v);
    case (kind)
      0: por_req = v;
      1: lvd_req = v;
      2: bad_addr_req = v;
      3: wdog_req = v;
      4: clkmon_fail = v;
      5: ext_low = v;
      default: begin wdog_req = v; clkmon_fail = v; end
    endcase
  endtask

  // Runs from the moment the last trigger is gone up to release of sys_rst_n.
  task automatic finish_seq(input bit ext_pulse, input bit restart, input bit late,
                            input string vtag);
    int cnt = 0;
    int k = 0;
    int ev;
    bit restarted = 0;
    string tg;
    forever begin
      @(negedge clk);
      if (!rst_pad_drv_low) break;
      cnt++;
      if (ext_pulse && cnt == 3) ext_low = 1'b0;
      if (late && cnt == 100) ext_low = 1'b1;
      if (restart && !restarted && cnt == 40) begin
        restarted = 1;
        lvd_req = 1'b1;
        @(negedge clk);
        lvd_req = 1'b0;
        cnt = 0;
      end
    end
    chk(cnt == REL_EDGES - 1, restart ? "R10" : "R3", cnt, REL_EDGES - 1);
    ev = exp_vec(late, exp_cm, exp_wd);
    forever begin
      @(negedge clk);
      k++;
      if (late && k == WAIT_EDGES + 16) ext_low = 1'b0;
      if (sys_rst_n || vec_valid || k > 400) break;
    end
    if (late) chk(k > WAIT_EDGES + 16, "R5", k, WAIT_EDGES + 17);
    else      chk(k == WAIT_EDGES, "R4", k, WAIT_EDGES);
    chk(sys_rst_n == 1'b0, "R8", sys_rst_n, 0);
    tg = (vtag != "") ? vtag : (late ? "R5" : (ev == 1 ? "R6" : "R7"));
    chk(int'(vec_sel) == ev, tg, vec_sel, ev);
    @(negedge clk);
    chk(sys_rst_n == 1'b1, "R8", sys_rst_n, 1);
    chk(vec_valid == 1'b1 && int'(vec_sel) == ev, "R8", vec_sel, ev);
    exp_wd = 0;
    exp_cm = 0;
  endtask

  task automatic run_trial(input int kind, input bit restart, input bit late,
                           input string vtag);
    @(negedge clk);
    chk(sys_rst_n == 1'b1, "R8", sys_rst_n, 1);
    #1;
    apply(kind, 1'b1);
    if (kind == 3 || kind == 6) exp_wd = 1;
    if (kind == 4 || kind == 6) exp_cm = 1;
    #1;
    chk(rst_pad_drv_low == 1'b1, "R1", rst_pad_drv_low, 1);
    chk(sys_rst_n == 1'b0 && vec_valid == 1'b0, "R1", sys_rst_n, 0);
    if (kind != 5) begin
      repeat (1 + $urandom % 3) @(negedge clk);
      #1;
      apply(kind, 1'b0);
    end
    finish_seq(kind == 5, restart, late, vtag);
  endtask

  task automatic selfclk_case();
    @(negedge clk);
    selfclk_en = 1'b1;
    #1 clkmon_fail = 1'b1;
    repeat (5) @(negedge clk);
    chk(rst_pad_drv_low == 1'b0, "R2", rst_pad_drv_low, 0);
    chk(sys_rst_n == 1'b1, "R2", sys_rst_n, 1);
    clkmon_fail = 1'b0;
    @(negedge clk);
    selfclk_en = 1'b0;
    run_trial(2, 0, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3: watchdog expired, actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    por_req = 1'b1; lvd_req = 1'b0; bad_addr_req = 1'b0; wdog_req = 1'b0;
    clkmon_fail = 1'b0; selfclk_en = 1'b0; ext_low = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(rst_pad_drv_low == 1'b1, "R1", rst_pad_drv_low, 1);
    chk(sys_rst_n == 1'b0, "R1", sys_rst_n, 0);
    chk(vec_valid == 1'b0, "R8", vec_valid, 0);
    por_req = 1'b0;
    finish_seq(0, 0, 0, "R7");

    run_trial(6, 0, 0, "R6");   // both flags: clock monitor wins
    run_trial(3, 0, 0, "R7");   // watchdog only
    run_trial(1, 0, 0, "R9");   // flags from before must be gone
    run_trial(3, 0, 1, "R5");   // pad held low past sample point
    run_trial(3, 1, 0, "R10");  // restart keeps watchdog flag
    run_trial(5, 0, 0, "R1");   // pad pulled low while idle
    selfclk_case();

    for (int i = 0; i < 20; i++) begin
      int kind = $urandom_range(0, 7);
      bit rs   = ($urandom % 4) == 0;
      bit lt   = ($urandom % 5) == 0;
      if (kind == 7) selfclk_case();
      else           run_trial(kind, rs, lt, "");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule